// File: doc/BRIEF.md
# Graphics Command Packet Parser

The parser takes a stream of 32-bit command words and cuts it into packets. The top byte of the first word of each packet is the opcode. A fixed per-opcode length rule gives the packet's word count. Words are collected in a local buffer. Once the last word has arrived, the whole packet is presented in one cycle to the rendering stage as a single wide vector, together with its length. No partial packet ever leaves the block, however long the gaps between its words are.

As packets pass, the parser keeps a bank of eight environment words and derives a 13-bit status field from them. Some packets update the bank:
- Environment opcodes overwrite one entry of the bank.
- Textured primitives patch the texture-page field of entry 1.

Two image opcodes are not forwarded to the renderer. They start a transfer in an external VRAM engine instead:
- For an upload, the following words pass straight through to the engine until it signals completion.
- For a download, the parser stops accepting words until the engine is done.

Top module: `cmd_packet_parser`

## Requirements
- R1: After reset, `in_ready` is 1, `pkt_valid`, `fb_dirty`, `xfer_start` and `vram_wvalid` are 0, and `status_lo` is 0. Environment entry i (bits 32i+31:32i of `env_regs`) holds (0xE0+i)<<24.
- R2: The total packet length, reported on `pkt_len`, is 1 plus an extra-word count chosen by the opcode:
  - 0x02 takes 2.
  - 0x20-0x23 take 3, 0x24-0x27 take 6, 0x28-0x2B take 4, 0x2C-0x2F take 8.
  - 0x30-0x33 take 5, 0x34-0x37 take 8, 0x38-0x3B take 7, 0x3C-0x3F take 11.
  - 0x40-0x47 take 2, 0x48-0x57 take 3, 0x58-0x5F take 4.
  - 0x60-0x63 take 2, 0x64-0x67 take 3, 0x68-0x6B take 1, 0x6C-0x6F take 0.
  - 0x70-0x73 take 1, 0x74-0x77 take 2, 0x78-0x7B take 1, 0x7C-0x7F take 2.
  - 0x80 takes 3, and 0xA0 and 0xC0 take 2.
  - Every other opcode takes 0.
- R3: A non-image packet is presented with `pkt_valid` for exactly one cycle, in the cycle after its last word is accepted. Word k of the packet appears at bits 32k+31:32k of `pkt_data`. Idle cycles between the words of a packet do not change the result.
- R4: A packet with opcode 0xE0-0xE7 writes its whole first word into environment entry (opcode & 7). The write is visible one cycle after acceptance.
- R5: When (opcode & 0xF4) is 0x24, bits 8:0 of environment entry 1 take bits 8:0 of packet word 4. When (opcode & 0xF4) is 0x34, they take bits 8:0 of packet word 5. The other bits of entry 1 are kept.
- R6: `status_lo` bits 10:0 equal bits 10:0 of environment entry 1, and bits 12:11 equal bits 1:0 of entry 6. Both follow in the same cycle that the entries change.
- R7: `fb_dirty` pulses together with the completion of any packet whose opcode lies in 0x02-0xBF, image upload included.
- R8: Opcodes 0xA0 (upload) and 0xC0 (download) are not forwarded on `pkt_valid`. In the cycle after their third word, `xfer_start` pulses once, with these fields:
  - `xfer_pos` set to word 1.
  - `xfer_size` set to word 2.
  - `xfer_read` set to 1 for 0xC0 and 0 for 0xA0.
- R9: After an upload starts, every accepted word appears on `vram_wdata` with `vram_wvalid` one cycle later and is not parsed. This holds up to and including the cycle in which `xfer_done` is high. Parsing resumes on the next cycle.
- R10: From the cycle `xfer_start` pulses for a download until the cycle after `xfer_done` is seen, `in_ready` is 0 and offered words are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word is taken when in_valid and in_ready are both high |
| pkt_valid | output | 1 | Complete packet present |
| pkt_len | output | 4 | Total words in the packet |
| pkt_data | output | 384 | Packet words, word k at bits 32k+31:32k |
| fb_dirty | output | 1 | Completed packet touches the framebuffer |
| xfer_start | output | 1 | Start pulse to the VRAM engine |
| xfer_read | output | 1 | 1 = download, 0 = upload |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_done | input | 1 | Engine reports the transfer finished |
| vram_wvalid | output | 1 | Upload data word valid |
| vram_wdata | output | 32 | Upload data word |
| env_regs | output | 256 | Environment bank, entry i at bits 32i+31:32i |
| status_lo | output | 13 | Status bits derived from the bank |

## Verification
Every registered result is due one cycle after the clock edge that accepts the word causing it. This covers `pkt_valid`, `pkt_len`, `fb_dirty`, the transfer start and its fields, the upload pass-through, and the environment and status updates. The only exception is `in_ready`, which depends on the current transfer state alone. The bench drives inputs on the falling edge and advances its reference model just after the rising edge. It compares every output at the following falling edge, so each expectation is sampled exactly one register stage after its cause. Loss of ready in a download is checked in the same cycle as the start pulse. Its return is checked in the cycle after `xfer_done`.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
    typedef enum logic [1:0] {
        ST_PARSE = 2'd0,
        ST_UPLOAD = 2'd1,
        ST_DOWNLOAD = 2'd2
    } cpp_state_e;

    localparam logic [7:0] OP_UPLOAD = 8'hA0;
    localparam logic [7:0] OP_DOWNLOAD = 8'hC0;
    localparam logic [7:0] OP_DIRTY_LO = 8'h02;
    localparam logic [7:0] OP_DIRTY_HI = 8'hBF;
    localparam logic [7:0] OP_PATCH_MASK = 8'hF4;
    localparam logic [7:0] OP_PATCH_FLAT = 8'h24;
    localparam logic [7:0] OP_PATCH_SHADED = 8'h34;
    localparam logic [4:0] OP_ENV_GROUP = 5'b11100;
endpackage

// File: rtl/cpp_len_dec.sv
module cpp_len_dec #(
    parameter int CW = 4
) (
    input  logic [7:0]    opcode,
    output logic [CW-1:0] total_words
);
    logic [3:0] extra;

    always_comb begin
        extra = 4'd0;
        unique case (opcode[7:5])
            3'd0: extra = (opcode == 8'h02) ? 4'd2 : 4'd0;
            3'd1: begin
                unique case (opcode[4:2])
                    3'd0: extra = 4'd3;
                    3'd1: extra = 4'd6;
                    3'd2: extra = 4'd4;
                    3'd3: extra = 4'd8;
                    3'd4: extra = 4'd5;
                    3'd5: extra = 4'd8;
                    3'd6: extra = 4'd7;
                    default: extra = 4'd11;
                endcase
            end
            3'd2: begin
                if (opcode[4:3] == 2'd0)
                    extra = 4'd2;
                else if (opcode[4:3] == 2'd3)
                    extra = 4'd4;
                else
                    extra = 4'd3;
            end
            3'd3: begin
                unique case (opcode[4:2])
                    3'd0: extra = 4'd2;
                    3'd1: extra = 4'd3;
                    3'd2: extra = 4'd1;
                    3'd3: extra = 4'd0;
                    3'd4: extra = 4'd1;
                    3'd5: extra = 4'd2;
                    3'd6: extra = 4'd1;
                    default: extra = 4'd2;
                endcase
            end
            3'd4: extra = (opcode == 8'h80) ? 4'd3 : 4'd0;
            3'd5: extra = (opcode == 8'hA0) ? 4'd2 : 4'd0;
            3'd6: extra = (opcode == 8'hC0) ? 4'd2 : 4'd0;
            default: extra = 4'd0;
        endcase
        total_words = CW'(extra) + CW'(1);
    end
endmodule

// File: rtl/cpp_env_file.sv
module cpp_env_file #(
    parameter int N_ENV = 8,
    parameter int DW = 32,
    parameter int PATCH_W = 9,
    parameter int STAT_W = 13,
    localparam int IDXW = $clog2(N_ENV)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic [DW-1:0]             wr_data,
    input  logic                      patch_en,
    input  logic [PATCH_W-1:0]        patch_val,
    output logic [N_ENV-1:0][DW-1:0]  env_o,
    output logic [STAT_W-1:0]         status_o
);
    localparam int TP_ENTRY = 1;
    localparam int MASK_ENTRY = 6;
    localparam int TP_BITS = 11;

    typedef struct packed {
        logic [N_ENV-1:0][DW-1:0] env;
        logic [STAT_W-1:0]        stat;
    } env_state_t;

    env_state_t st_d, st_q;
    logic [N_ENV-1:0][DW-1:0] env_rst;

    for (genvar g = 0; g < N_ENV; g++) begin : g_rst
        assign env_rst[g] = DW'((32'hE0 + g) << 24);
    end

    always_comb begin
        st_d = st_q;
        if (wr_en)
            st_d.env[wr_idx] = wr_data;
        if (patch_en)
            st_d.env[TP_ENTRY][PATCH_W-1:0] = patch_val;
        st_d.stat = {st_d.env[MASK_ENTRY][STAT_W-TP_BITS-1:0],
                     st_d.env[TP_ENTRY][TP_BITS-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.env <= env_rst;
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign env_o = st_q.env;
    assign status_o = st_q.stat;
endmodule

// File: rtl/cmd_packet_parser.sv
module cmd_packet_parser #(
    parameter int MAX_WORDS = 12,
    parameter int N_ENV = 8,
    parameter int DW = 32,
    localparam int CW = $clog2(MAX_WORDS + 1),
    localparam int IDXW = $clog2(N_ENV),
    localparam int PATCH_W = 9,
    localparam int STAT_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DW-1:0]           in_data,
    output logic                    in_ready,
    output logic                    pkt_valid,
    output logic [CW-1:0]           pkt_len,
    output logic [MAX_WORDS*DW-1:0] pkt_data,
    output logic                    fb_dirty,
    output logic                    xfer_start,
    output logic                    xfer_read,
    output logic [DW-1:0]           xfer_pos,
    output logic [DW-1:0]           xfer_size,
    input  logic                    xfer_done,
    output logic                    vram_wvalid,
    output logic [DW-1:0]           vram_wdata,
    output logic [N_ENV*DW-1:0]     env_regs,
    output logic [STAT_W-1:0]       status_lo
);
    import cpp_pkg::*;

    localparam int FLAT_WORD = 4;
    localparam int SHADED_WORD = 5;

    typedef struct packed {
        cpp_state_e                   st;
        logic [CW-1:0]                cnt;
        logic [CW-1:0]                need;
        logic [MAX_WORDS-1:0][DW-1:0] pbuf;
        logic                         pkt_v;
        logic                         dirty;
        logic                         xs;
        logic                         xr;
        logic [DW-1:0]                pos;
        logic [DW-1:0]                size;
        logic                         vw;
        logic [DW-1:0]                vd;
    } ctl_t;

    ctl_t d, q;
    logic [CW-1:0] hdr_total;
    logic [CW-1:0] total;
    logic [7:0]    op;
    logic          accept;
    logic          env_we;
    logic [IDXW-1:0] env_idx;
    logic [DW-1:0] env_wdata;
    logic          patch_we;
    logic [PATCH_W-1:0] patch_bits;

    cpp_len_dec #(.CW(CW)) u_len (
        .opcode      (in_data[31:24]),
        .total_words (hdr_total)
    );

    assign in_ready = (q.st != ST_DOWNLOAD);
    assign accept = in_valid && in_ready;
    assign total = (q.cnt == '0) ? hdr_total : q.need;

    always_comb begin
        d = q;
        d.pkt_v = 1'b0;
        d.dirty = 1'b0;
        d.xs = 1'b0;
        d.vw = 1'b0;
        env_we = 1'b0;
        env_idx = '0;
        env_wdata = '0;
        patch_we = 1'b0;
        patch_bits = '0;
        op = q.pbuf[0][31:24];
        unique case (q.st)
            ST_PARSE: begin
                if (accept && (q.cnt < CW'(MAX_WORDS))) begin
                    d.pbuf[q.cnt] = in_data;
                    if (q.cnt == '0)
                        d.need = hdr_total;
                    op = d.pbuf[0][31:24];
                    if (q.cnt + CW'(1) == total) begin
                        d.cnt = '0;
                        d.dirty = (op >= OP_DIRTY_LO) && (op <= OP_DIRTY_HI);
                        if (op[7:3] == OP_ENV_GROUP) begin
                            env_we = 1'b1;
                            env_idx = IDXW'(op[2:0]);
                            env_wdata = d.pbuf[0];
                        end
                        if ((op & OP_PATCH_MASK) == OP_PATCH_FLAT) begin
                            patch_we = 1'b1;
                            patch_bits = d.pbuf[FLAT_WORD][PATCH_W-1:0];
                        end else if ((op & OP_PATCH_MASK) == OP_PATCH_SHADED) begin
                            patch_we = 1'b1;
                            patch_bits = d.pbuf[SHADED_WORD][PATCH_W-1:0];
                        end
                        if (op == OP_UPLOAD || op == OP_DOWNLOAD) begin
                            d.xs = 1'b1;
                            d.xr = (op == OP_DOWNLOAD);
                            d.pos = d.pbuf[1];
                            d.size = d.pbuf[2];
                            d.st = (op == OP_DOWNLOAD) ? ST_DOWNLOAD : ST_UPLOAD;
                        end else begin
                            d.pkt_v = 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            end
            ST_UPLOAD: begin
                if (accept) begin
                    d.vw = 1'b1;
                    d.vd = in_data;
                end
                if (xfer_done)
                    d.st = ST_PARSE;
            end
            default: begin
                if (xfer_done)
                    d.st = ST_PARSE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st <= ST_PARSE;
            q.cnt <= '0;
            q.need <= CW'(1);
            q.pbuf <= '0;
            q.pkt_v <= 1'b0;
            q.dirty <= 1'b0;
            q.xs <= 1'b0;
            q.xr <= 1'b0;
            q.pos <= '0;
            q.size <= '0;
            q.vw <= 1'b0;
            q.vd <= '0;
        end else begin
            q <= d;
        end
    end

    cpp_env_file #(
        .N_ENV   (N_ENV),
        .DW      (DW),
        .PATCH_W (PATCH_W),
        .STAT_W  (STAT_W)
    ) u_env (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (env_we),
        .wr_idx    (env_idx),
        .wr_data   (env_wdata),
        .patch_en  (patch_we),
        .patch_val (patch_bits),
        .env_o     (env_regs),
        .status_o  (status_lo)
    );

    assign pkt_valid = q.pkt_v;
    assign pkt_len = q.need;
    assign pkt_data = q.pbuf;
    assign fb_dirty = q.dirty;
    assign xfer_start = q.xs;
    assign xfer_read = q.xr;
    assign xfer_pos = q.pos;
    assign xfer_size = q.size;
    assign vram_wvalid = q.vw;
    assign vram_wdata = q.vd;
endmodule

// File: rtl/cmd_packet_parser_chk.sv
module cmd_packet_parser_chk #(
    parameter int MAX_WORDS = 12,
    parameter int N_ENV = 8,
    parameter int DW = 32,
    localparam int CW = $clog2(MAX_WORDS + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_ready,
    input logic                pkt_valid,
    input logic [CW-1:0]       pkt_len,
    input logic                xfer_start,
    input logic                xfer_read,
    input logic                vram_wvalid,
    input logic [N_ENV*DW-1:0] env_regs
);
    // R3: a packet only completes on an accepted word
    assert_pkt_after_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> $past(in_valid && in_ready));

    // R2: reported length lies within the buffer
    assert_len_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_len >= CW'(1) && pkt_len <= CW'(MAX_WORDS)));

    // R8: image opcodes are never forwarded as packets, and start pulses last one cycle
    assert_img_not_forwarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && xfer_start));
    assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // R10: a download start drops ready at once
    assert_download_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && xfer_read) |-> !in_ready);

    // R9: upload data only follows an accepted word
    assert_upload_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vram_wvalid |-> $past(in_valid && in_ready));

    // R4: the environment bank moves only after an accepted word
    assert_env_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid && in_ready) |-> $stable(env_regs));
endmodule

bind cmd_packet_parser cmd_packet_parser_chk #(
    .MAX_WORDS (MAX_WORDS),
    .N_ENV     (N_ENV),
    .DW        (DW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .pkt_valid   (pkt_valid),
    .pkt_len     (pkt_len),
    .xfer_start  (xfer_start),
    .xfer_read   (xfer_read),
    .vram_wvalid (vram_wvalid),
    .env_regs    (env_regs)
);

// File: tb/cmd_packet_parser_tb_top.sv
module cmd_packet_parser_tb_top;
    localparam int MAXW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic xfer_done = 1'b0;
    logic in_ready, pkt_valid, fb_dirty, xfer_start, xfer_read, vram_wvalid;
    logic [3:0] pkt_len;
    logic [MAXW*32-1:0] pkt_data;
    logic [31:0] xfer_pos, xfer_size, vram_wdata;
    logic [255:0] env_regs;
    logic [12:0] status_lo;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cmd_packet_parser dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .pkt_data(pkt_data), .fb_dirty(fb_dirty), .xfer_start(xfer_start),
        .xfer_read(xfer_read), .xfer_pos(xfer_pos), .xfer_size(xfer_size),
        .xfer_done(xfer_done), .vram_wvalid(vram_wvalid), .vram_wdata(vram_wdata),
        .env_regs(env_regs), .status_lo(status_lo)
    );

    // reference model state
    int m_mode = 0;            // 0 parse, 1 upload, 2 download
    logic [31:0] m_q[$];
    logic [31:0] m_pkt[$];
    logic [31:0] m_env[8];
    bit m_pv, m_dirty, m_xs, m_xr, m_vw;
    logic [31:0] m_pos, m_size, m_vd;

    function automatic int extra_of(input logic [7:0] op);
        if (op == 8'h02) return 2;
        if (op >= 8'h20 && op <= 8'h23) return 3;
        if (op >= 8'h24 && op <= 8'h27) return 6;
        if (op >= 8'h28 && op <= 8'h2B) return 4;
        if (op >= 8'h2C && op <= 8'h2F) return 8;
        if (op >= 8'h30 && op <= 8'h33) return 5;
        if (op >= 8'h34 && op <= 8'h37) return 8;
        if (op >= 8'h38 && op <= 8'h3B) return 7;
        if (op >= 8'h3C && op <= 8'h3F) return 11;
        if (op >= 8'h40 && op <= 8'h47) return 2;
        if (op >= 8'h48 && op <= 8'h57) return 3;
        if (op >= 8'h58 && op <= 8'h5F) return 4;
        if (op >= 8'h60 && op <= 8'h63) return 2;
        if (op >= 8'h64 && op <= 8'h67) return 3;
        if (op >= 8'h68 && op <= 8'h6B) return 1;
        if (op >= 8'h70 && op <= 8'h73) return 1;
        if (op >= 8'h74 && op <= 8'h77) return 2;
        if (op >= 8'h78 && op <= 8'h7B) return 1;
        if (op >= 8'h7C && op <= 8'h7F) return 2;
        if (op == 8'h80) return 3;
        if (op == 8'hA0 || op == 8'hC0) return 2;
        return 0;
    endfunction

    task automatic model_reset();
        m_mode = 0;
        m_q.delete();
        m_pkt.delete();
        for (int i = 0; i < 8; i++) m_env[i] = (32'hE0 + i) << 24;
        m_pv = 0; m_dirty = 0; m_xs = 0; m_xr = 0; m_vw = 0;
        m_pos = 0; m_size = 0; m_vd = 0;
    endtask

    task automatic model_step(input bit v, input logic [31:0] dat, input bit dn);
        bit acc;
        logic [7:0] op;
        acc = v && (m_mode != 2);
        m_pv = 0; m_dirty = 0; m_xs = 0; m_vw = 0;
        if (m_mode == 0) begin
            if (acc) begin
                m_q.push_back(dat);
                op = m_q[0][31:24];
                if (m_q.size() == 1 + extra_of(op)) begin
                    m_dirty = (op >= 8'h02 && op <= 8'hBF);
                    if (op >= 8'hE0 && op <= 8'hE7) m_env[op - 8'hE0] = m_q[0];
                    if ((op & 8'hF4) == 8'h24) m_env[1][8:0] = m_q[4][8:0];
                    if ((op & 8'hF4) == 8'h34) m_env[1][8:0] = m_q[5][8:0];
                    if (op == 8'hA0 || op == 8'hC0) begin
                        m_xs = 1; m_xr = (op == 8'hC0);
                        m_pos = m_q[1]; m_size = m_q[2];
                        m_mode = (op == 8'hC0) ? 2 : 1;
                    end else begin
                        m_pv = 1;
                        m_pkt = m_q;
                    end
                    m_q.delete();
                end
            end
        end else if (m_mode == 1) begin
            if (acc) begin m_vw = 1; m_vd = dat; end
            if (dn) m_mode = 0;
        end else begin
            if (dn) m_mode = 0;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(in_ready == (m_mode != 2), "R10", "in_ready", 64'(in_ready), 64'(m_mode != 2));
        chk(pkt_valid == m_pv, "R3", "pkt_valid", 64'(pkt_valid), 64'(m_pv));
        if (m_pv && pkt_valid) begin
            chk(pkt_len == 4'(m_pkt.size()), "R2", "pkt_len", 64'(pkt_len), 64'(m_pkt.size()));
            for (int k = 0; k < m_pkt.size(); k++)
                chk(pkt_data[32*k +: 32] == m_pkt[k], "R3", "pkt word",
                    64'(pkt_data[32*k +: 32]), 64'(m_pkt[k]));
        end
        chk(fb_dirty == m_dirty, "R7", "fb_dirty", 64'(fb_dirty), 64'(m_dirty));
        chk(xfer_start == m_xs, "R8", "xfer_start", 64'(xfer_start), 64'(m_xs));
        if (m_xs) begin
            chk(xfer_read == m_xr, "R8", "xfer_read", 64'(xfer_read), 64'(m_xr));
            chk(xfer_pos == m_pos, "R8", "xfer_pos", 64'(xfer_pos), 64'(m_pos));
            chk(xfer_size == m_size, "R8", "xfer_size", 64'(xfer_size), 64'(m_size));
        end
        chk(vram_wvalid == m_vw, "R9", "vram_wvalid", 64'(vram_wvalid), 64'(m_vw));
        if (m_vw)
            chk(vram_wdata == m_vd, "R9", "vram_wdata", 64'(vram_wdata), 64'(m_vd));
        for (int i = 0; i < 8; i++)
            chk(env_regs[32*i +: 32] == m_env[i], "R4 R5", "env entry",
                64'(env_regs[32*i +: 32]), 64'(m_env[i]));
        chk(status_lo == {m_env[6][1:0], m_env[1][10:0]}, "R6", "status_lo",
            64'(status_lo), 64'({m_env[6][1:0], m_env[1][10:0]}));
    endtask

    task automatic step(input bit v, input logic [31:0] dat, input bit dn);
        @(negedge clk);
        compare();
        in_valid = v; in_data = dat; xfer_done = dn;
        @(posedge clk);
        #1;
        model_step(v, dat, dn);
    endtask

    task automatic word(input logic [31:0] dat);
        step(1'b1, dat, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'h0, 1'b0);
    endtask

    task automatic packet(input logic [7:0] op, input logic [31:0] seed);
        word({op, seed[23:0]});
        for (int k = 1; k <= extra_of(op); k++)
            word(seed * 32'd97 + 32'(k) * 32'h0101_0103);
    endtask

    task automatic run_all();
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(in_ready === 1'b1, "R1", "in_ready", 64'(in_ready), 64'(1));
        chk(pkt_valid === 1'b0 && fb_dirty === 1'b0 && xfer_start === 1'b0 && vram_wvalid === 1'b0,
            "R1", "pulses", 64'({pkt_valid, fb_dirty, xfer_start, vram_wvalid}), 64'(0));
        chk(status_lo === 13'h0, "R1", "status_lo", 64'(status_lo), 64'(0));
        for (int i = 0; i < 8; i++)
            chk(env_regs[32*i +: 32] === (32'hE0 + i) << 24, "R1", "env reset",
                64'(env_regs[32*i +: 32]), 64'((32'hE0 + i) << 24));
        // R4 R6: environment writes
        word(32'hE1_0007FF);
        word(32'hE6_000003);
        word(32'hE3_123456);
        // R3: partial packet with gaps
        word(32'h20_000001);
        idle(3);
        word(32'h1111_1111);
        idle(2);
        word(32'h2222_2222);
        word(32'h3333_3333);
        // R5: flat and shaded texture patches
        packet(8'h24, 32'h0000_0155);
        packet(8'h34, 32'h0000_00AA);
        packet(8'h3C, 32'h0000_0042);
        // R7: boundary opcodes
        packet(8'h01, 32'h5);
        packet(8'h02, 32'h6);
        packet(8'hBF, 32'h7);
        // R8 R9: upload with pass-through, done on a word cycle
        word(32'hA0_000000);
        word(32'h0010_0020);
        word(32'h0002_0004);
        word(32'hDEAD_0001);
        idle(1);
        word(32'hDEAD_0002);
        step(1'b1, 32'hDEAD_0003, 1'b1);
        packet(8'h68, 32'h9);
        // R10: download stall, offered words dropped
        word(32'hC0_000000);
        word(32'h0003_0005);
        word(32'h0001_0001);
        step(1'b1, 32'hE2_FFFFFF, 1'b0);
        step(1'b1, 32'hE2_FFFFFF, 1'b0);
        step(1'b0, 32'h0, 1'b1);
        packet(8'h7C, 32'hA);
        // R2: every non-image opcode
        for (int op = 0; op < 256; op++)
            if (op != 8'hA0 && op != 8'hC0)
                packet(8'(op), 32'(op * 7 + 1));
        idle(3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule